// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block keeps a device's internal reset asserted until its supply and clocks can be trusted. After the power-on input drops, it runs a chain of timed waits. First comes a power-up delay counted in slow RC ticks. Next is an oscillator settling count of 1024 oscillator ticks, used only for crystal-type modes. Last is an optional PLL lock delay. Reset is released only when the chain has reached the run state and the external reset pin is high.

The block also watches a digital low-supply flag. If brown-out detection is enabled and the flag stays high long enough, the block drops back into a brown-out state and keeps reset asserted. When the flag clears, the power-up delay runs again. A wake event in the run state repeats only the clock-related waits. A sticky flag records that a brown-out happened, and a write-one-to-clear pulse clears it.

All tick inputs are single-cycle enables in the `clk` domain. Every pin is a plain control or status level; the block has no streaming interface and no back-pressure.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_i` is high, `state_o` is IDLE_POR (code 0), `rst_o` is 1 and `bor_seen_o` is 0.
- R2: With `cfg_pwrt_en_i` set, the first clock edge after `por_i` falls enters PWRT (code 1), which lasts exactly TPWRT cycles of `rc_tick_i`.
- R3: OST (code 2) lasts 1024 cycles of `osc_tick_i` and is entered only in crystal modes (`cfg_osc_mode_i` 0, 1 or 2; 3 is RC), after the power-up path or a wake. In RC mode OST is skipped.
- R4: With `cfg_pll_en_i` set, PLL (code 3) follows OST for TPLL RC ticks; the chain then enters RUN (code 5) and `rst_o` falls on that same edge.
- R5: With `cfg_bor_en_i` set, `bor_low_i` held high on TBOR consecutive RC ticks forces BOR (code 4) with `rst_o` high, from any state except IDLE_POR.
- R6: A low-supply pulse seen on fewer than TBOR RC ticks, or any pulse while `cfg_bor_en_i` is 0, leaves the state and `rst_o` unchanged.
- R7: `bor_seen_o` becomes 1 on entry to BOR and stays 1 until a `bor_seen_clr_i` pulse. A new entry in the same cycle wins over the clear.
- R8: `wake_i` in RUN starts OST (crystal mode) and then PLL (if enabled) without running PWRT. In RC mode with the PLL off, it has no effect.
- R9: When `bor_low_i` clears in BOR, the block enters PWRT (or goes straight to RUN if the power-up timer is off) and then RUN, skipping OST and PLL. If `bor_low_i` rises during PWRT, the block returns to BOR on the next edge, and the next PWRT starts again from zero.
- R10: `rst_o` is 1 whenever the state is not RUN. A low `ext_rst_n_i` raises `rst_o` without waiting for a clock edge.
- R11: The wait chain runs while `ext_rst_n_i` is low. If RUN has been reached, `rst_o` falls on the first clock edge after the pin returns high.
- R12: In RC mode with the power-up timer and PLL disabled, RUN and a low `rst_o` follow on the first edge after `por_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_low_i | input | 1 | Low-supply comparator flag |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| osc_tick_i | input | 1 | One-cycle enable per oscillator cycle |
| rc_tick_i | input | 1 | One-cycle enable per slow RC cycle |
| wake_i | input | 1 | Wake-from-sleep event |
| cfg_osc_mode_i | input | 2 | 0 LP, 1 XT, 2 HS, 3 RC |
| cfg_pwrt_en_i | input | 1 | Power-up timer enable |
| cfg_bor_en_i | input | 1 | Brown-out detection enable |
| cfg_pll_en_i | input | 1 | PLL lock wait enable |
| bor_seen_clr_i | input | 1 | Write-one-to-clear for the sticky flag |
| rst_o | output | 1 | Internal reset, active high |
| state_o | output | 3 | Current state code |
| bor_seen_o | output | 1 | Sticky brown-out-occurred flag |

## Verification
The bench targets a low-supply flag that returns partway through the post-brown-out power-up wait. A design that failed to reset the counter there would release reset early. It also sends a dip one tick shorter than the filter; an off-by-one filter would fall into BOR. It holds the external pin low across a whole power-up; a design that paused the chain on the pin, instead of counting through, would release reset long after the pin rises instead of one edge later. Finally, it checks wakes and RC-mode power-ups, where a design that ran the power-up wait or the oscillator count when it should not would take the wrong path or show the wrong timing.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_BOR  = 3'd4,
    ST_RUN  = 3'd5
  } rts_state_e;

  localparam logic [1:0] OSC_RC = 2'd3;

  function automatic logic is_xtal(input logic [1:0] mode);
    return mode != OSC_RC;
  endfunction
endpackage

// File: rtl/rts_bor_filter.sv
module rts_bor_filter #(
  parameter int TBOR = 3
) (
  input  logic clk,
  input  logic por_i,
  input  logic en_i,
  input  logic low_i,
  input  logic tick_i,
  output logic trip_o
);
  localparam int FW = (TBOR < 2) ? 1 : $clog2(TBOR + 1);
  localparam logic [FW-1:0] LAST = FW'(TBOR - 1);

  logic [FW-1:0] run_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                     run_q <= '0;
    else if (!en_i || !low_i)      run_q <= '0;
    else if (tick_i && run_q != LAST) run_q <= run_q + FW'(1);
  end

  assign trip_o = en_i & low_i & tick_i & (run_q == LAST);

  generate
    if (TBOR >= 2) begin : g_chk
      // R5: a trip needs the flag to have been high before this cycle
      p_trip_held_r5: assert property (@(posedge clk) disable iff (por_i)
        trip_o |-> $past(low_i));
    end
  endgenerate
endmodule

// File: rtl/rts_wait_timer.sv
module rts_wait_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = tick_i & (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                 cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + CW'(1);
  end

  // R2: the count never passes the limit of the wait in progress
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (por_i)
    cnt_q < limit_i);
endmodule

// File: rtl/rts_rst_release.sv
module rts_rst_release #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  input  logic busy_i,
  output logic rst_o
);
  logic hold;
  logic [STAGES-1:0] sync_q;

  assign hold = por_i | ~pin_n_i;

  always_ff @(posedge clk or posedge hold) begin
    if (hold) sync_q <= '1;
    else      sync_q <= STAGES'(sync_q << 1);
  end

  assign rst_o = sync_q[STAGES-1] | busy_i;

  // R11: reset only falls while the pin is high
  p_release_pin_r11: assert property (@(posedge clk) disable iff (por_i)
    $fell(rst_o) |-> pin_n_i);
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
  import rts_pkg::*;
#(
  parameter int TPWRT      = 8,
  parameter int OST_CYC    = 1024,
  parameter int TPLL       = 4,
  parameter int TBOR       = 3,
  parameter int REL_STAGES = 1
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       bor_low_i,
  input  logic       ext_rst_n_i,
  input  logic       osc_tick_i,
  input  logic       rc_tick_i,
  input  logic       wake_i,
  input  logic [1:0] cfg_osc_mode_i,
  input  logic       cfg_pwrt_en_i,
  input  logic       cfg_bor_en_i,
  input  logic       cfg_pll_en_i,
  input  logic       bor_seen_clr_i,
  output logic       rst_o,
  output logic [2:0] state_o,
  output logic       bor_seen_o
);
  localparam int MAX_A = (TPWRT > TPLL) ? TPWRT : TPLL;
  localparam int MAX_W = (MAX_A > OST_CYC) ? MAX_A : OST_CYC;
  localparam int CW    = $clog2(MAX_W + 1);

  rts_state_e    state_q, state_d, after_pwrt, after_ost, after_wake;
  logic          cold_q, busy_q, seen_q;
  logic          xtal, trip, t_done, t_tick, t_clear;
  logic [CW-1:0] t_limit;

  assign xtal = is_xtal(cfg_osc_mode_i);

  rts_bor_filter #(.TBOR(TBOR)) i_filter (
    .clk(clk), .por_i(por_i), .en_i(cfg_bor_en_i), .low_i(bor_low_i),
    .tick_i(rc_tick_i), .trip_o(trip)
  );

  always_comb begin
    case (state_q)
      ST_PWRT: t_limit = CW'(TPWRT);
      ST_OST:  t_limit = CW'(OST_CYC);
      ST_PLL:  t_limit = CW'(TPLL);
      default: t_limit = CW'(1);
    endcase
    t_tick  = (state_q == ST_OST) ? osc_tick_i : rc_tick_i;
    t_clear = (state_d != state_q);
  end

  rts_wait_timer #(.CW(CW)) i_timer (
    .clk(clk), .por_i(por_i), .clear_i(t_clear), .tick_i(t_tick),
    .limit_i(t_limit), .done_o(t_done)
  );

  always_comb begin
    after_ost  = cfg_pll_en_i ? ST_PLL : ST_RUN;
    after_wake = xtal ? ST_OST : after_ost;
    if (cold_q && xtal)              after_pwrt = ST_OST;
    else if (cold_q && cfg_pll_en_i) after_pwrt = ST_PLL;
    else                             after_pwrt = ST_RUN;

    state_d = state_q;
    case (state_q)
      ST_IDLE: state_d = cfg_pwrt_en_i ? ST_PWRT : after_wake;
      ST_PWRT: begin
        if (cfg_bor_en_i && bor_low_i) state_d = ST_BOR;
        else if (t_done)               state_d = after_pwrt;
      end
      ST_OST:  if (t_done) state_d = after_ost;
      ST_PLL:  if (t_done) state_d = ST_RUN;
      ST_BOR:  if (!(cfg_bor_en_i && bor_low_i))
                 state_d = cfg_pwrt_en_i ? ST_PWRT : ST_RUN;
      ST_RUN:  if (wake_i) state_d = after_wake;
      default: state_d = ST_IDLE;
    endcase
    if (trip && state_q != ST_IDLE && state_q != ST_BOR) state_d = ST_BOR;
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      state_q <= ST_IDLE;
      cold_q  <= 1'b1;
      busy_q  <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_RUN);
      if (state_d == ST_BOR) cold_q <= 1'b0;
      if (state_d == ST_BOR && state_q != ST_BOR) seen_q <= 1'b1;
      else if (bor_seen_clr_i)                    seen_q <= 1'b0;
    end
  end

  rts_rst_release #(.STAGES(REL_STAGES)) i_release (
    .clk(clk), .por_i(por_i), .pin_n_i(ext_rst_n_i), .busy_i(busy_q),
    .rst_o(rst_o)
  );

  assign state_o    = state_q;
  assign bor_seen_o = seen_q;

  // R10: reset stays asserted outside the run state
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (por_i)
    (state_q != ST_RUN) |-> rst_o);
  // R3: oscillator wait entered only for a crystal mode
  p_ost_xtal_r3: assert property (@(posedge clk) disable iff (por_i)
    (state_q != ST_OST) ##1 (state_q == ST_OST) |-> $past(is_xtal(cfg_osc_mode_i)));
  // R9: low flag during the power-up wait returns to brown-out
  p_reentry_r9: assert property (@(posedge clk) disable iff (por_i)
    (state_q == ST_PWRT && cfg_bor_en_i && bor_low_i) |=> (state_q == ST_BOR));
  // R7: sticky flag is set on brown-out entry
  p_sticky_r7: assert property (@(posedge clk) disable iff (por_i)
    $rose(state_q == ST_BOR) |-> bor_seen_o);
  // R8: a wake never runs the power-up wait
  p_wake_skip_r8: assert property (@(posedge clk) disable iff (por_i)
    (state_q == ST_RUN && wake_i) |=> (state_q != ST_PWRT));
endmodule

// File: tb/test_rst_timeout_seq.sv
module test_rst_timeout_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TPWRT = 8;
  localparam int OSTC  = 1024;
  localparam int TPLL  = 4;
  localparam int TBOR  = 3;
  localparam int S_IDLE = 0, S_PWRT = 1, S_OST = 2, S_PLL = 3, S_BOR = 4, S_RUN = 5;

  typedef struct {
    int    st;
    logic  rst;
    int    cyc;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic por = 1'b1, low = 1'b0, pin_n = 1'b1, osc_t = 1'b1, rc_t = 1'b1, wake = 1'b0;
  logic [1:0] mode = 2'd1;
  logic pwrt_en = 1'b1, bor_en = 1'b1, pll_en = 1'b1, clr = 1'b0;
  logic rst;
  logic [2:0] st;
  logic seen;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic mon_en = 1'b0;
  logic done = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_timeout_seq #(.TPWRT(TPWRT), .OST_CYC(OSTC), .TPLL(TPLL), .TBOR(TBOR)) i_rst_timeout_seq (
    .clk(clk), .por_i(por), .bor_low_i(low), .ext_rst_n_i(pin_n),
    .osc_tick_i(osc_t), .rc_tick_i(rc_t), .wake_i(wake),
    .cfg_osc_mode_i(mode), .cfg_pwrt_en_i(pwrt_en), .cfg_bor_en_i(bor_en),
    .cfg_pll_en_i(pll_en), .bor_seen_clr_i(clr),
    .rst_o(rst), .state_o(st), .bor_seen_o(seen)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int s, input logic r, input int dc, input string tag);
    exp_t e;
    e.st = s; e.rst = r; e.cyc = cyc + dc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    step(3);
  endtask

  // monitor: pops one expected item per change of state or reset
  initial begin
    logic [3:0] last;
    last = 4'b0001;
    forever begin
      @(posedge clk);
      #1;
      if (mon_en && {1'b0, st, rst} != {1'b0, last}) begin
        last = {st, rst};
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL unexpected change: actual state %0d rst %0d expected no change (cycle %0d)",
                   st, rst, cyc);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " state"}, int'(st), e.st);
          check({e.tag, " rst"}, int'(rst), int'(e.rst));
          check({e.tag, " cycle"}, cyc, e.cyc);
        end
      end
    end
  end

  initial begin
    step(100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 state", int'(st), S_IDLE);
    check("R1 rst", int'(rst), 1);
    check("R1 seen", int'(seen), 0);
    mon_en = 1'b1;

    // R2 R3 R4 full power-up with crystal and PLL
    por = 1'b0;
    push(S_PWRT, 1, 1, "R2");
    push(S_OST, 1, 1 + TPWRT, "R3");
    push(S_PLL, 1, 1 + TPWRT + OSTC, "R4");
    push(S_RUN, 0, 1 + TPWRT + OSTC + TPLL, "R4");
    drain();

    // R8 wake repeats only the clock waits
    wake = 1'b1;
    push(S_OST, 1, 1, "R8");
    push(S_PLL, 1, 1 + OSTC, "R8");
    push(S_RUN, 0, 1 + OSTC + TPLL, "R8");
    step(1);
    wake = 1'b0;
    drain();

    // R6 dip one tick short of the filter
    low = 1'b1;
    step(TBOR - 1);
    low = 1'b0;
    step(5);
    check("R6 short dip state", int'(st), S_RUN);
    check("R6 short dip rst", int'(rst), 0);

    // R6 detection disabled
    bor_en = 1'b0;
    low = 1'b1;
    step(10);
    low = 1'b0;
    step(2);
    bor_en = 1'b1;
    step(2);
    check("R6 disabled state", int'(st), S_RUN);
    check("R6 disabled seen", int'(seen), 0);

    // R5 R7 R9 brown-out, recovery, re-entry during the power-up wait
    low = 1'b1;
    push(S_BOR, 1, TBOR, "R5");
    step(TBOR + 4);
    check("R7 seen set", int'(seen), 1);
    low = 1'b0;
    push(S_PWRT, 1, 1, "R9");
    step(4);
    low = 1'b1;
    push(S_BOR, 1, 1, "R9 reentry");
    step(1);
    low = 1'b0;
    push(S_PWRT, 1, 1, "R9");
    push(S_RUN, 0, 1 + TPWRT, "R9 full restart");
    drain();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    step(1);
    check("R7 seen cleared", int'(seen), 0);

    // R10 pin low raises reset without a clock edge
    pin_n = 1'b0;
    push(S_RUN, 1, 1, "R10");
    #1;
    check("R10 async rst", int'(rst), 1);
    step(3);
    pin_n = 1'b1;
    push(S_RUN, 0, 1, "R11");
    drain();

    // R11 chain runs while pin held low
    por = 1'b1;
    pin_n = 1'b0;
    push(S_IDLE, 1, 1, "R1");
    step(1);
    por = 1'b0;
    push(S_PWRT, 1, 1, "R11");
    push(S_OST, 1, 1 + TPWRT, "R11");
    push(S_PLL, 1, 1 + TPWRT + OSTC, "R11");
    push(S_RUN, 1, 1 + TPWRT + OSTC + TPLL, "R11 held");
    drain();
    pin_n = 1'b1;
    push(S_RUN, 0, 1, "R11 release");
    drain();

    // R12 RC mode, no power-up timer, no PLL
    mode = 2'd3;
    pwrt_en = 1'b0;
    pll_en = 1'b0;
    por = 1'b1;
    push(S_IDLE, 1, 1, "R1");
    step(1);
    por = 1'b0;
    push(S_RUN, 0, 1, "R12");
    drain();
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    step(3);
    check("R3 R8 RC wake state", int'(st), S_RUN);
    check("R3 R8 RC wake rst", int'(rst), 0);

    // R3 crystal mode without power-up timer goes straight to OST
    mode = 2'd2;
    por = 1'b1;
    push(S_IDLE, 1, 1, "R1");
    step(1);
    por = 1'b0;
    push(S_OST, 1, 1, "R3");
    push(S_RUN, 0, 1 + OSTC, "R3");
    drain();

    check("queue empty", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule